// File: doc/BRIEF.md
# Flash Whole-Array Erase Sequencer

This block is the control and status front end of an on-chip flash controller. A 32-bit APB-style register port gives access to an address pointer, a clock divisor, a control word, an interrupt word and four data words. Software starts a whole-array erase by writing the control word. That write carries an unlock key, an erase code and the start bit together. A start is accepted only when both the key and the code are correct and the debug port is enabled. Any other start is refused and flagged as an access failure.

An accepted start raises busy and an erase request toward the flash array. The request stays high until the array returns a one-cycle completion pulse. At completion the hardware clears busy and the start bit, relocks the key and sets a done flag. Done and access-fail are sticky flags that software clears by writing 1 to them. Each flag has an enable bit, and the interrupt line is high while any enabled flag is set.

Top module: `flc_erase_seq`

## Requirements
- R1: After reset every register reads 0, and erase_req and irq are low.
- R2: Registers are decoded on a full access (psel, penable and pwrite high at a rising edge). The 32-bit address pointer is at 0x00. Data words 0 to 3 are at 0x30, 0x34, 0x38 and 0x3C and are fully read/write. Reads of any unmapped offset return 0.
- R3: The clock divisor at 0x04 stores bits 7:0. Bits 31:8 always read 0.
- R4: The control word is at 0x08. It holds the start bit in bit 0, the erase code in bits 15:8, busy (read only) in bit 24 and the unlock key in bits 31:28. A control write made while idle, with bit 0 = 1, key = 0x2, code = 0xAA and dbg_en high, sets busy and the start bit, and raises erase_req from the next cycle.
- R5: erase_req stays high until erase_done is seen high while busy. That edge clears busy and the start bit and sets the done flag (interrupt word bit 0).
- R6: A start write whose key is not 0x2 or whose code is not 0xAA sets the access-fail flag (interrupt word bit 1) and starts no erase.
- R7: A start write with a correct key and code while dbg_en is low sets access-fail and starts no erase.
- R8: While busy, writes to the control word leave the key, code and start fields unchanged.
- R9: After completion or a refused start, the key field reads 0.
- R10: The interrupt word is at 0x24. Writing 1 to bit 0 or bit 1 clears that flag. If hardware sets a flag in the same cycle as a write-1 clears it, the flag ends up set.
- R11: Bits 9 and 8 of the interrupt word are read/write enables for the fail and done flags. irq is high exactly when a set flag has its enable set.
- R12: erase_done while idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write (1) or read (0) |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| dbg_en | input | 1 | Debug port enabled |
| erase_req | output | 1 | Whole-array erase request |
| erase_done | input | 1 | Array completion pulse |
| irq | output | 1 | Interrupt |

## Verification
Two events can land on the same edge: the array's completion pulse setting the done flag, and a software write-1 to the interrupt word clearing that flag. The bench drives erase_done during the access phase of an interrupt-word write that has bit 0 set. It then reads the interrupt word back and expects done still set. A second, later clear with no completion pulse must then leave the flag at 0.

// File: rtl/flc_erase_seq.sv
module flc_erase_seq #(
  parameter int AW = 8,
  parameter int DIVW = 8,
  parameter logic [3:0] UNLOCK_KEY = 4'h2,
  parameter logic [7:0] ERASE_CODE = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  input  logic          dbg_en,
  output logic          erase_req,
  input  logic          erase_done,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_ADDR = AW'(8'h00);
  localparam logic [AW-1:0] OFS_DIV  = AW'(8'h04);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h08);
  localparam logic [AW-1:0] OFS_INTR = AW'(8'h24);
  localparam logic [AW-1:0] OFS_DAT  = AW'(8'h30);

  logic [31:0]     addr_q;
  logic [DIVW-1:0] div_q;
  logic [3:0]      key_q;
  logic [7:0]      code_q;
  logic            go_q, busy_q;
  logic [1:0]      flag_q, en_q;
  logic [31:0]     dat_q [4];

  logic wr, wr_ctrl, wr_intr, start_try, key_ok, start_ok, start_bad, fin;
  logic dat_hit;

  assign wr        = psel & penable & pwrite;
  assign wr_ctrl   = wr && paddr == OFS_CTRL;
  assign wr_intr   = wr && paddr == OFS_INTR;
  assign dat_hit   = paddr[AW-1:4] == OFS_DAT[AW-1:4] && paddr[1:0] == 2'b00;
  assign start_try = wr_ctrl & ~busy_q & pwdata[0];
  assign key_ok    = pwdata[31:28] == UNLOCK_KEY && pwdata[15:8] == ERASE_CODE;
  assign start_ok  = start_try & key_ok & dbg_en;
  assign start_bad = start_try & ~(key_ok & dbg_en);
  assign fin       = busy_q & erase_done;

  assign erase_req = busy_q;
  assign irq       = |(flag_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      div_q  <= '0;
      key_q  <= '0;
      code_q <= '0;
      go_q   <= 1'b0;
      busy_q <= 1'b0;
      flag_q <= '0;
      en_q   <= '0;
      for (int i = 0; i < 4; i++) dat_q[i] <= '0;
    end else begin
      if (wr && paddr == OFS_ADDR) addr_q <= pwdata;
      if (wr && paddr == OFS_DIV)  div_q  <= pwdata[DIVW-1:0];
      if (wr && dat_hit)           dat_q[paddr[3:2]] <= pwdata;
      if (wr_ctrl && !busy_q) begin
        code_q <= pwdata[15:8];
        key_q  <= start_bad ? 4'h0 : pwdata[31:28];
        if (start_ok) begin
          go_q   <= 1'b1;
          busy_q <= 1'b1;
        end
      end else if (fin) begin
        go_q   <= 1'b0;
        busy_q <= 1'b0;
        key_q  <= 4'h0;
      end
      if (wr_intr) en_q <= pwdata[9:8];
      flag_q <= (flag_q & ~(wr_intr ? pwdata[1:0] : 2'b00)) | {start_bad, fin};
    end
  end

  always_comb begin
    prdata = '0;
    unique case (1'b1)
      paddr == OFS_ADDR: prdata = addr_q;
      paddr == OFS_DIV:  prdata = 32'(div_q);
      paddr == OFS_CTRL: prdata = {key_q, 3'b000, busy_q, 8'h00, code_q, 7'h00, go_q};
      paddr == OFS_INTR: prdata = {22'h0, en_q, 6'h0, flag_q};
      dat_hit:           prdata = dat_q[paddr[3:2]];
      default:           prdata = '0;
    endcase
  end

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && !erase_done |=> erase_req);
  a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && erase_done |=> !erase_req && flag_q[0]);
  a_r6_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    start_try && !key_ok |=> !erase_req && flag_q[1]);
  a_r7_no_debug: assert property (@(posedge clk) disable iff (!rst_n)
    start_try && !dbg_en |=> !erase_req && flag_q[1]);
  a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !erase_done |=> $stable(key_q) && $stable(code_q));
  a_r9_relock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> key_q == 4'h0);
  a_r12_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && erase_done && !start_try && !wr_intr |=> $stable(flag_q) && !erase_req);
endmodule

// File: tb/flc_erase_seq_bench.sv
module flc_erase_seq_bench;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0, dbg_en = 0, erase_done = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic erase_req, irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  flc_erase_seq u_flc_erase_seq (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .dbg_en(dbg_en),
    .erase_req(erase_req), .erase_done(erase_done), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic dn = 1'b0);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; erase_done = dn;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; erase_done = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    psel = 0; penable = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); erase_done = 1;
    @(negedge clk); erase_done = 0;
  endtask

  function automatic logic [31:0] ctrl_word(logic [3:0] k, logic [7:0] c, logic b, logic g);
    return {k, 3'b000, b, 8'h00, c, 7'h00, g};
  endfunction

  function automatic logic [31:0] start_word(logic [3:0] k, logic [7:0] c);
    return {k, 12'h000, c, 8'h01};
  endfunction

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 erase_req", 32'(erase_req), 0);
    check("R1 irq", 32'(irq), 0);
    foreach (v[i]) if (i < 16) begin
      rd(8'(i * 4), w); check("R1 reg", w, 0);
    end

    // R2 / R3 register access
    for (int i = 0; i < 10; i++) begin
      v = $urandom(); wr(8'h00, v); rd(8'h00, w); check("R2 addr", w, v);
      v = $urandom(); wr(8'h04, v); rd(8'h04, w); check("R3 clkdiv", w, {24'h0, v[7:0]});
    end
    for (int i = 0; i < 4; i++) begin
      wr(8'h30 + 8'(i * 4), 32'hA5A50000 + 32'(i));
    end
    for (int i = 0; i < 4; i++) begin
      rd(8'h30 + 8'(i * 4), w); check("R2 data", w, 32'hA5A50000 + 32'(i));
    end
    rd(8'h10, w); check("R2 unmapped", w, 0);
    rd(8'h40, w); check("R2 unmapped", w, 0);

    // R12 idle done pulse
    pulse_done();
    rd(8'h24, w); check("R12 idle done", w, 0);
    check("R12 req", 32'(erase_req), 0);

    // R4 R5 R8 R9 directed erase with irq
    dbg_en = 1;
    wr(8'h24, 32'h0000_0300);
    wr(8'h08, start_word(4'h2, 8'hAA));
    check("R4 req", 32'(erase_req), 1);
    rd(8'h08, w); check("R4 ctrl", w, ctrl_word(4'h2, 8'hAA, 1, 1));
    wr(8'h08, start_word(4'h5, 8'h11));
    rd(8'h08, w); check("R8 locked", w, ctrl_word(4'h2, 8'hAA, 1, 1));
    repeat (5) @(negedge clk);
    check("R5 held", 32'(erase_req), 1);
    check("R11 irq low", 32'(irq), 0);
    pulse_done();
    check("R5 req low", 32'(erase_req), 0);
    rd(8'h08, w); check("R9 relock", w, ctrl_word(4'h0, 8'hAA, 0, 0));
    rd(8'h24, w); check("R5 done", w, 32'h0000_0301);
    check("R11 irq", 32'(irq), 1);
    wr(8'h24, 32'h0000_0201);
    check("R11 irq off", 32'(irq), 0);
    rd(8'h24, w); check("R10 w1c", w, 32'h0000_0200);

    // R10 set and clear in same cycle
    wr(8'h08, start_word(4'h2, 8'hAA));
    wr(8'h24, 32'h0000_0001, 1'b1);
    rd(8'h24, w); check("R10 set wins", w, 32'h0000_0001);
    wr(8'h24, 32'h0000_0001);
    rd(8'h24, w); check("R10 cleared", w, 0);

    // R6 R7 R9 random starts
    for (int n = 0; n < 40; n++) begin
      logic [3:0] k; logic [7:0] c; logic ok;
      k = ($urandom() % 2) ? 4'h2 : 4'($urandom());
      c = ($urandom() % 2) ? 8'hAA : 8'($urandom());
      dbg_en = ($urandom() % 4) != 0;
      ok = (k == 4'h2) && (c == 8'hAA) && dbg_en;
      wr(8'h08, start_word(k, c));
      check(ok ? "R4 rnd req" : (dbg_en ? "R6 rnd req" : "R7 rnd req"), 32'(erase_req), 32'(ok));
      if (ok) begin
        v = $urandom(); wr(8'h08, v);
        rd(8'h08, w); check("R8 rnd", w, ctrl_word(4'h2, 8'hAA, 1, 1));
        pulse_done();
        rd(8'h24, w); check("R5 rnd", w, 32'h1);
      end else begin
        rd(8'h24, w); check(dbg_en ? "R6 fail" : "R7 fail", w, 32'h2);
      end
      rd(8'h08, w); check("R9 rnd", w, ctrl_word(4'h0, c, 0, 0));
      wr(8'h24, 32'h3);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule